// File: doc/BRIEF.md
# Token Ring Frame Purger

This controller sits inside a token-ring MAC and removes orphaned frames and long fragments that their sender never took off the ring. The station runs a purge cycle only while it holds the token. When the token is captured, the block first lets any queued frames of its own go out. It then requests two void frames and, after them, the token. From the cycle in which the first void is requested, every frame or fragment that ends at the receiver is stripped instead of repeated.

The cycle ends when one of the station's own void frames comes back without error. It also ends when a token or a ring-initialization frame is received. One good own void is enough to end it, even though two were sent. The second void therefore returns after the cycle has closed and is repeated like any other frame. A void from another purger on the same ring carries a foreign source address. Such a void is stripped but does not end this station's cycle, so several purgers can run at once without disrupting the ring.

A one-cycle status pulse marks each stripped frame, and a wrapping counter records completed purge cycles.

Top module: `token_purger`

## Requirements
- R1: After reset, `strip`, `strip_pulse`, `tx_req` and `purge_count` are 0. `token_grab` has an effect only while no transmit sequence is running.
- R2: If `tx_pending` is high when the token is captured, the block requests own frames (`tx_kind` 00) for as long as `tx_pending` stays high. Voids are requested only in the cycle after `tx_pending` goes low.
- R3: A purge sequence requests exactly two voids (`tx_kind` 01), each of which must be acknowledged by `tx_ack`. The token (`tx_kind` 10) follows, and after its acknowledge `tx_req` drops.
- R4: `strip` rises in the same cycle in which the first void is requested.
- R5: While `strip` is high, every received frame end (`rx_eof`) is stripped, whatever its type, source or check flag. `strip_pulse` is high for the one cycle after that frame end.
- R6: The cycle ends, with `strip` low after the edge, on an own void. An own void is a frame end with `rx_type` 01, `rx_src` equal to `station_addr` and `rx_crc_ok` high.
- R7: The cycle also ends on a received token (`rx_type` 10) or ring-initialization frame (`rx_type` 11), whatever the source or check flag.
- R8: The cycle does not end on data frames (`rx_type` 00), on voids with a foreign source, or on own voids with a bad check flag. Each cycle that ends counts once in `purge_count`. A second own void that arrives after the end is not stripped.
- R9: With `purge_en` low, the token is passed on with no voids and nothing is stripped. Dropping `purge_en` during a cycle clears `strip` at the next edge without counting that cycle.
- R10: If a new cycle starts in the same cycle as an ending event, the start wins. `strip` stays high, `purge_count` is unchanged, and the frame that arrived is still stripped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| purge_en | input | 1 | Enables purge cycles for this station |
| station_addr | input | ADDR_W | This station's address |
| token_grab | input | 1 | Strobe: token has been captured |
| tx_pending | input | 1 | Own frames are queued for transmission |
| tx_ack | input | 1 | Transmitter has finished the requested frame |
| tx_req | output | 1 | A frame transmission is requested |
| tx_kind | output | 2 | Requested frame: 00 own, 01 void, 10 token |
| rx_eof | input | 1 | Strobe: a received frame or fragment ends |
| rx_type | input | 2 | Received type: 00 data, 01 void, 10 token, 11 init |
| rx_src | input | ADDR_W | Source address of the received frame |
| rx_crc_ok | input | 1 | Received frame check was good |
| strip | output | 1 | High while received frames are stripped |
| strip_pulse | output | 1 | One-cycle pulse per stripped frame |
| purge_count | output | CNT_W | Completed purge cycles (wraps) |

## Verification
Two events can fall in the same cycle: the start of a new purge cycle and an ending event from the purge cycle still open. The bench provokes this by holding an earlier cycle open after its token has been released. It then drives `token_grab` together with the end of an own good void, in one cycle. The result is judged after the edge: `strip` must stay high, `purge_count` must not move, and `strip_pulse` must mark the frame. A later own void must then close the cycle and count it exactly once.

// File: rtl/token_purger.sv
module token_purger #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              purge_en,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              token_grab,
  input  logic              tx_pending,
  input  logic              tx_ack,
  output logic              tx_req,
  output logic [1:0]        tx_kind,
  input  logic              rx_eof,
  input  logic [1:0]        rx_type,
  input  logic [ADDR_W-1:0] rx_src,
  input  logic              rx_crc_ok,
  output logic              strip,
  output logic              strip_pulse,
  output logic [CNT_W-1:0]  purge_count
);

  localparam logic [1:0] K_DATA  = 2'b00;
  localparam logic [1:0] K_VOID  = 2'b01;
  localparam logic [1:0] K_TOKEN = 2'b10;
  localparam logic [1:0] K_INIT  = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_OWN, S_VOID1, S_VOID2, S_TOKEN} st_t;

  st_t              state, state_n;
  logic             active, active_n;
  logic             start, own_void, end_evt;
  logic             pulse_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_n = state;
    case (state)
      S_IDLE:  if (token_grab)
                 state_n = tx_pending ? S_OWN : (purge_en ? S_VOID1 : S_TOKEN);
      S_OWN:   if (!tx_pending)
                 state_n = purge_en ? S_VOID1 : S_TOKEN;
      S_VOID1: if (!purge_en)  state_n = S_TOKEN;
               else if (tx_ack) state_n = S_VOID2;
      S_VOID2: if (!purge_en || tx_ack) state_n = S_TOKEN;
      S_TOKEN: if (tx_ack) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  assign start    = (state_n == S_VOID1) && (state != S_VOID1);
  assign own_void = (rx_type == K_VOID) && (rx_src == station_addr) && rx_crc_ok;
  assign end_evt  = rx_eof && (own_void || rx_type == K_TOKEN || rx_type == K_INIT);

  always_comb begin
    if (!purge_en)    active_n = 1'b0;
    else if (start)   active_n = 1'b1;
    else if (end_evt) active_n = 1'b0;
    else              active_n = active;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      active  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state   <= state_n;
      active  <= active_n;
      pulse_q <= active && rx_eof;
      if (active && purge_en && end_evt && !start)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    tx_req  = 1'b0;
    tx_kind = K_DATA;
    case (state)
      S_OWN:   begin tx_req = tx_pending; tx_kind = K_DATA;  end
      S_VOID1,
      S_VOID2: begin tx_req = 1'b1;       tx_kind = K_VOID;  end
      S_TOKEN: begin tx_req = 1'b1;       tx_kind = K_TOKEN; end
      default: begin tx_req = 1'b0;       tx_kind = K_DATA;  end
    endcase
  end

  assign strip       = active;
  assign strip_pulse = pulse_q;
  assign purge_count = cnt_q;

  // R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strip_pulse |-> $past(strip));

  // R9
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !purge_en |=> !strip);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_count != $past(purge_count)) |-> $fell(strip));

  // R3
  void_then_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_req) && $past(tx_kind) == K_VOID && tx_req && tx_kind != K_VOID)
      |-> tx_kind == K_TOKEN);

  // R4
  void_strips_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_kind == K_VOID && !$past(tx_req && tx_kind == K_VOID) && purge_en)
      |-> strip);

endmodule

// File: tb/token_purger_bench.sv
module token_purger_bench;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam logic [ADDR_W-1:0] ME    = 16'h0A5C;
  localparam logic [ADDR_W-1:0] OTHER = 16'h1234;

  logic clk = 0, rst_n = 0, purge_en = 1;
  logic [ADDR_W-1:0] station_addr = ME;
  logic token_grab = 0, tx_pending = 0, tx_ack = 0;
  logic tx_req;
  logic [1:0] tx_kind;
  logic rx_eof = 0;
  logic [1:0] rx_type = 0;
  logic [ADDR_W-1:0] rx_src = 0;
  logic rx_crc_ok = 0;
  logic strip, strip_pulse;
  logic [CNT_W-1:0] purge_count;

  int checks = 0, fails = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  token_purger #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_token_purger (
    .clk(clk), .rst_n(rst_n), .purge_en(purge_en), .station_addr(station_addr),
    .token_grab(token_grab), .tx_pending(tx_pending), .tx_ack(tx_ack),
    .tx_req(tx_req), .tx_kind(tx_kind), .rx_eof(rx_eof), .rx_type(rx_type),
    .rx_src(rx_src), .rx_crc_ok(rx_crc_ok), .strip(strip),
    .strip_pulse(strip_pulse), .purge_count(purge_count));

  // vector: [4:3] rx_type, [2] own source, [1] crc ok, [0] ends the cycle
  localparam logic [4:0] VEC [7] = '{
    {2'b00, 1'b0, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b0, 1'b0, 1'b1},
    {2'b00, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rx_frame(logic [1:0] t, logic [ADDR_W-1:0] s, logic ok);
    rx_eof = 1; rx_type = t; rx_src = s; rx_crc_ok = ok;
    tick();
    rx_eof = 0; rx_type = 0; rx_src = 0; rx_crc_ok = 0;
  endtask

  task automatic open_purge();
    token_grab = 1;
    tick();
    token_grab = 0;
    tx_ack = 1;
    tick(); tick(); tick();
    tx_ack = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 strip after reset", strip, 0);
    chk("R1 tx_req after reset", tx_req, 0);
    chk("R1 count after reset", purge_count, 0);
    chk("R1 pulse after reset", strip_pulse, 0);
    rst_n = 1;
    tick();
    rx_frame(2'b00, OTHER, 1);
    chk("R1 no strip while idle", strip_pulse, 0);

    // table walk
    foreach (VEC[i]) begin
      open_purge();
      chk("R4 strip open after sequence", strip, 1);
      rx_frame(VEC[i][4:3], VEC[i][2] ? ME : OTHER, VEC[i][1]);
      chk("R5 pulse for stripped frame", strip_pulse, 1);
      chk("R6 R7 R8 end decision", strip, !VEC[i][0]);
      if (VEC[i][0]) exp_cnt++;
      chk("R8 count after event", purge_count, exp_cnt[CNT_W-1:0]);
      if (!VEC[i][0]) begin
        rx_frame(2'b01, ME, 1);
        exp_cnt++;
        chk("R6 own void closes", strip, 0);
        chk("R8 count after close", purge_count, exp_cnt[CNT_W-1:0]);
      end
    end

    // R2 own frames go first
    tx_pending = 1; token_grab = 1;
    tick();
    token_grab = 0;
    chk("R2 own frame requested", {tx_req, tx_kind}, 3'b100);
    chk("R2 not stripping yet", strip, 0);
    tick();
    chk("R2 still own frame", {tx_req, tx_kind}, 3'b100);
    tx_pending = 0;
    tick();
    chk("R3 first void", {tx_req, tx_kind}, 3'b101);
    chk("R4 strip with first void", strip, 1);
    tick();
    chk("R3 void waits for ack", {tx_req, tx_kind}, 3'b101);
    tx_ack = 1;
    tick();
    chk("R3 second void", {tx_req, tx_kind}, 3'b101);
    tick();
    chk("R3 token after voids", {tx_req, tx_kind}, 3'b110);
    tick();
    tx_ack = 0;
    chk("R3 idle after token", tx_req, 0);
    // R8 one own void ends; the second passes
    rx_frame(2'b01, ME, 1);
    exp_cnt++;
    chk("R8 first void ends", strip, 0);
    rx_frame(2'b01, ME, 1);
    chk("R8 second void not stripped", strip_pulse, 0);
    chk("R8 counted once", purge_count, exp_cnt[CNT_W-1:0]);

    // R1 token_grab ignored mid-sequence
    token_grab = 1;
    tick();
    token_grab = 0;
    token_grab = 1;
    tick();
    token_grab = 0;
    chk("R1 grab ignored in sequence", {tx_req, tx_kind}, 3'b101);
    tx_ack = 1;
    tick(); tick(); tick();
    tx_ack = 0;
    chk("R1 back to idle", tx_req, 0);

    // R9 purge_en low mid-cycle: cleared without count
    purge_en = 0;
    tick();
    chk("R9 strip cleared", strip, 0);
    chk("R9 not counted", purge_count, exp_cnt[CNT_W-1:0]);
    // R9 no voids with purge_en low
    token_grab = 1;
    tick();
    token_grab = 0;
    chk("R9 token straight away", {tx_req, tx_kind}, 3'b110);
    chk("R9 no strip", strip, 0);
    tx_ack = 1;
    tick();
    tx_ack = 0;
    rx_frame(2'b00, OTHER, 1);
    chk("R9 data repeated", strip_pulse, 0);
    purge_en = 1;
    tick();

    // R10 start and end event in the same cycle
    open_purge();
    token_grab = 1;
    rx_eof = 1; rx_type = 2'b01; rx_src = ME; rx_crc_ok = 1;
    tick();
    token_grab = 0;
    rx_eof = 0; rx_type = 0; rx_src = 0; rx_crc_ok = 0;
    chk("R10 strip held", strip, 1);
    chk("R10 count unchanged", purge_count, exp_cnt[CNT_W-1:0]);
    chk("R10 frame stripped", strip_pulse, 1);
    chk("R10 void requested", {tx_req, tx_kind}, 3'b101);
    tx_ack = 1;
    tick(); tick(); tick();
    tx_ack = 0;
    rx_frame(2'b01, ME, 1);
    exp_cnt++;
    chk("R10 later close counted once", purge_count, exp_cnt[CNT_W-1:0]);
    chk("R10 closed", strip, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule